// File: doc/BRIEF.md
# Four-Bank Interleaved Block Memory Controller

This controller fronts a main memory built from four word-interleaved banks and serves the cache's four-word block refills. The cache presents a block address, and the controller spends one cycle broadcasting it to every bank. The four banks then run their access together. After the access, the four words go back to the cache one per cycle over a single word-wide return bus. Each word is tagged with its position in the block and qualified by a valid strobe.

The bank that holds a word is chosen by the two low bits of its word address. Word i of any block therefore always sits in bank i. A one-word write, such as a write-buffer drain, touches only the bank that its address selects. It costs the address cycle plus the bank access, and returns nothing.

Bank storage is modelled inside the block at cycle level, so that the timing can be checked. A parameter switches the controller to a sequential organisation. In that mode every word repeats the address, access and transfer steps. This gives the slow baseline for comparison.

Top module: `ilv_mem_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `busy` and `rd_valid` are 0.
- R2: A request is taken only when `req_valid` is 1 in a cycle where `busy` is 0. A request presented while `busy` is 1 is dropped and has no effect on bank contents or on timing.
- R3: In interleaved mode (`SEQ_MODE`=0), a block read accepted at the clock edge that opens cycle A holds `busy` high for cycles A to A+14, which is 15 cycles. It asserts `rd_valid` in cycles A+11 to A+14 (1 address cycle, 10 access cycles, then 4 transfer cycles).
- R4: The words of a read come back in the order 0, 1, 2, 3. Word i carries `rd_idx`=i and the data stored at word address {block, i}, which is held in bank i.
- R5: A write (`req_write`=1) holds `busy` for 11 cycles and never asserts `rd_valid`. It changes only the word at `req_addr`, in bank `req_addr[1:0]`. The other three words of that block keep their values.
- R6: In sequential mode (`SEQ_MODE`=1), word k of a read comes back in cycle A+11+12k, `busy` lasts 48 cycles, and a write still lasts 11 cycles.
- R7: `busy` falls in the cycle after the last word. A request presented in that first idle cycle is accepted at the next edge.
- R8: On a read, bits [1:0] of `req_addr` are ignored. The whole aligned block always comes back starting at word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1: one-word write, 0: block read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | Request in progress |
| rd_valid | output | 1 | Return word valid |
| rd_idx | output | 2 | Word position of the returned word in the block |
| rd_data | output | DATA_W | Returned word |

## Verification
Two events can fall in the same cycle. The first is a new request arriving while the final word of a block is still on the return bus, or while a write is still in flight. The second is a request arriving in the very first cycle after `busy` has dropped. The bench drives a conflicting write into the middle of a read and judges it dropped when two things hold: the later readback of that block still matches the reference contents, and the busy length is unchanged. The bench also issues every request as soon as `busy` falls. A scoreboard then confirms each returned word arrives in exactly the cycle counted from the accept edge.

// File: rtl/ilv_mem_ctrl.sv
module ilv_mem_ctrl #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int ADDR_CYC = 1,
  parameter int ACC_CYC  = 10,
  parameter bit SEQ_MODE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              rd_valid,
  output logic [1:0]        rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  localparam int NB    = 4;
  localparam int ROW_W = ADDR_W - 2;
  localparam int DEPTH = 1 << ROW_W;
  localparam int MAXC  = (ADDR_CYC > ACC_CYC) ? ADDR_CYC : ACC_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  typedef enum logic [1:0] {IDLE, ADDR, ACC, XFER} ph_t;

  ph_t              ph;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       widx;
  logic [ROW_W-1:0] row_q;
  logic [1:0]       bank_q;
  logic             wr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [NB*DATA_W-1:0] lat_bus;

  wire accept   = req_valid && (ph == IDLE);
  wire addr_end = (ph == ADDR) && (cnt == CNT_W'(ADDR_CYC - 1));
  wire acc_end  = (ph == ACC)  && (cnt == CNT_W'(ACC_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph      <= IDLE;
      cnt     <= '0;
      widx    <= '0;
      row_q   <= '0;
      bank_q  <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
    end else begin
      case (ph)
        IDLE: if (accept) begin
          ph      <= ADDR;
          cnt     <= '0;
          widx    <= '0;
          row_q   <= req_addr[ADDR_W-1:2];
          bank_q  <= req_addr[1:0];
          wr_q    <= req_write;
          wdata_q <= req_wdata;
        end
        ADDR: if (addr_end) begin
          ph  <= ACC;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        ACC: if (acc_end) begin
          ph  <= wr_q ? IDLE : XFER;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        XFER: begin
          if (widx == 2'd3) ph <= IDLE;
          else if (SEQ_MODE) ph <= ADDR;
          widx <= widx + 1'b1;
        end
        default: ph <= IDLE;
      endcase
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] lat;
    wire hit_rd = !SEQ_MODE || (widx == 2'(b));
    always_ff @(posedge clk) begin
      if (acc_end) begin
        if (wr_q && bank_q == 2'(b)) mem[row_q] <= wdata_q;
        else if (!wr_q && hit_rd) lat <= mem[row_q];
      end
    end
    assign lat_bus[b*DATA_W +: DATA_W] = lat;
  end

  assign busy     = (ph != IDLE);
  assign rd_valid = (ph == XFER);
  assign rd_idx   = widx;
  assign rd_data  = lat_bus[widx*DATA_W +: DATA_W];

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_valid);
  p_no_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> ($stable(row_q) && $stable(wr_q) && $stable(wdata_q)));
  p_valid_in_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> busy);
  p_idx_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_idx != 2'd3) |=> (!rd_valid || rd_idx == $past(rd_idx) + 2'd1));
  p_write_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_q) |-> !rd_valid);
  p_busy_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(wr_q) || ($past(rd_valid) && $past(rd_idx) == 2'd3)));
endmodule

// File: tb/sim_ilv_mem_ctrl.sv
module sim_ilv_mem_ctrl;
  localparam int AC = 1, XC = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        rv[2], rw[2];
  logic [7:0]  ra[2];
  logic [31:0] rd[2];
  logic        bsy[2], vld[2];
  logic [1:0]  idx[2];
  logic [31:0] dat[2];

  ilv_mem_ctrl #(.SEQ_MODE(1'b0)) u0 (.clk(clk), .rst_n(rst_n), .req_valid(rv[0]), .req_write(rw[0]),
    .req_addr(ra[0]), .req_wdata(rd[0]), .busy(bsy[0]), .rd_valid(vld[0]), .rd_idx(idx[0]), .rd_data(dat[0]));
  ilv_mem_ctrl #(.SEQ_MODE(1'b1)) u1 (.clk(clk), .rst_n(rst_n), .req_valid(rv[1]), .req_write(rw[1]),
    .req_addr(ra[1]), .req_wdata(rd[1]), .busy(bsy[1]), .rd_valid(vld[1]), .rd_idx(idx[1]), .rd_data(dat[1]));

  typedef struct { int t; logic [1:0] i; logic [31:0] d; string r; } exp_t;
  exp_t q0[$], q1[$];
  logic [31:0] model[2][256];
  int cyc = 0, checks = 0, errors = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", r, act, exp, cyc);
    end
  endtask

  task automatic mon(input int u, ref exp_t q[$]);
    exp_t e;
    if (q.size() == 0) begin
      chk(0, "R5 unexpected rd_valid", 1, 0);
      return;
    end
    e = q.pop_front();
    chk(cyc == e.t, {e.r, " word cycle"}, cyc, e.t);
    chk(idx[u] == e.i, {e.r, " rd_idx"}, idx[u], e.i);
    chk(dat[u] == e.d, {e.r, " rd_data"}, dat[u], e.d);
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    if (vld[0]) mon(0, q0);
    if (vld[1]) mon(1, q1);
  end

  // caller is at a negedge; returns at the negedge where busy is low again
  task automatic op(input int u, input bit wr, input logic [7:0] a, input logic [31:0] d,
                    input string r, input bit inject);
    int acc, n, t;
    exp_t e;
    while (bsy[u]) @(negedge clk);
    rv[u] = 1; rw[u] = wr; ra[u] = a; rd[u] = d;
    @(negedge clk);
    acc = cyc;
    rv[u] = 0; rw[u] = 0;
    if (wr) model[u][a] = d;
    else for (int i = 0; i < 4; i++) begin
      t = u ? acc + AC + XC + i * (AC + XC + 1) : acc + AC + XC + i;
      e.t = t; e.i = 2'(i); e.d = model[u][{a[7:2], 2'(i)}]; e.r = r;
      if (u == 0) q0.push_back(e); else q1.push_back(e);
    end
    n = 0;
    while (bsy[u]) begin
      n++;
      if (inject && n == 3) begin rv[u] = 1; rw[u] = 1; ra[u] = a; rd[u] = 32'hDEAD_BEEF; end
      if (inject && n == 5) rv[u] = 0;
      @(negedge clk);
    end
    rw[u] = 0;
    chk(n == (wr ? AC + XC : (u ? 4 * (AC + XC + 1) : AC + XC + 4)),
        wr ? "R5 write busy length" : (u ? "R6 seq busy length" : (inject ? "R2 busy length" : "R3 busy length")),
        n, wr ? AC + XC : (u ? 4 * (AC + XC + 1) : AC + XC + 4));
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int u = 0; u < 2; u++) begin rv[u] = 0; rw[u] = 0; ra[u] = 0; rd[u] = 0; end
    repeat (3) @(negedge clk);
    chk(!bsy[0] && !vld[0] && !bsy[1] && !vld[1], "R1 reset state", {bsy[0], vld[0]}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!bsy[0] && !vld[0], "R1 after reset", {bsy[0], vld[0]}, 0);
    for (int i = 0; i < 8; i++) op(0, 1, 8'h40 + 8'(i), 32'hA000_0000 + 32'(i * 17), "R5", 0);
    op(0, 0, 8'h40, 0, "R3 R4 block 0x40", 0);
    op(0, 0, 8'h44, 0, "R7 back-to-back read", 0);
    op(0, 0, 8'h46, 0, "R8 unaligned read", 0);
    op(0, 1, 8'h45, 32'h1234_5678, "R5", 0);
    op(0, 0, 8'h44, 0, "R5 single-bank write", 0);
    op(0, 0, 8'h40, 0, "R2 request during read", 1);
    op(0, 0, 8'h40, 0, "R2 readback after dropped write", 0);
    for (int i = 0; i < 4; i++) op(1, 1, 8'h20 + 8'(i), 32'h5500_0000 + 32'(i), "R5", 0);
    op(1, 0, 8'h20, 0, "R6 sequential read", 0);
    op(1, 0, 8'h21, 0, "R6 R8 sequential unaligned", 0);
    repeat (4) @(negedge clk);
    chk(q0.size() == 0 && q1.size() == 0, "R3 all words returned", q0.size() + q1.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule